// File: doc/BRIEF.md
# USB IN Endpoint Transfer-End Controller

This block handles the IN data path of one endpoint of a USB function. A CPU or a DMA engine writes 16-bit halfwords into the endpoint's packet buffer. The block counts the bytes it accepts against a total that software loads. It drives a DMA request line in either single-transfer or block-transfer pacing. It turns the buffer contents into packets for the serial interface engine, which is modelled here as one-cycle IN-token and ACK pulses.

Software controls how a transfer ends through a six-bit control word. It marks the final write of a transfer, and it can mark that this write carries one byte rather than two. It can also ask for a zero-length packet when the final packet is exactly one full buffer long. The final-write mark and the odd-byte mark clear themselves on hardware events. Software can also hold the DMA request off once the byte total has run out, until it loads a new total.

Top module: `usbf_in_xfer_end`

## Requirements
- R1: After synchronous reset, `ctl_rd`, `tot_left`, `tot_done`, `tx_start`, `tx_nak` and `wr_ack` are all zero. Control word bits: bit0 final-write mark, bit1 odd-byte mark, bit2 zero-length-packet enable, bit3 single-transfer DMA mode, bit4 hold DREQ after total, bit5 byte-counter enable. A `ctl_we` pulse overwrites all six bits, and software wins over a hardware clear in the same cycle.
- R2: Each accepted halfword is stored at buffer halfword address fill/2, starting from 0 after each sent packet. `sie_rdata` returns the word at `sie_raddr` one clock later.
- R3: When the buffer reaches MAXP bytes a packet is queued. While a packet is queued, `dreq` is low and writes get no `wr_ack` and are not stored. The next `in_tok` gives a `tx_start` pulse with `tx_len` = MAXP, and the matching `in_ack` frees the buffer.
- R4: A write accepted while bit0 is set is the final write. It queues a packet of all bytes written so far, even if the buffer is short. Bit0 stays set until the `in_ack` for that packet, and clears on the clock of that ACK.
- R5: If bit1 is also set, the final write counts one byte (low byte valid), so the packet length is odd. Bit1 clears on the clock that accepts the final write.
- R6: With bit2 set and a final packet of exactly MAXP bytes, the `in_tok` after that packet's ACK gets `tx_start` with `tx_len` = 0. With bit2 clear it gets `tx_nak`.
- R7: An `in_tok` with no queued packet and no pending zero-length packet gives a one-cycle `tx_nak` and no `tx_start`.
- R8: In single mode `dreq` is low in the cycle `wr_ack` is high, and it may return in the next cycle. In block mode `dreq` stays high across accepted writes until the buffer fills.
- R9: `tot_we` loads `tot_left` and clears `tot_done`. With bit5 set, each accepted write reduces `tot_left` by 2, or by 1 for an odd final write, stopping at 0. `tot_done` rises when the count reaches 0. With bit5 clear the count does not change.
- R10: With bit4 set and `tot_done` high, `dreq` stays low even when the buffer has room, until `tot_we` loads a new total. With bit4 clear, `dreq` returns once the buffer has room.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 6 | New control word |
| ctl_rd | output | 6 | Current control word |
| tot_we | input | 1 | Load strobe for the byte total |
| tot_wdata | input | CNT_W | Byte total to load |
| tot_left | output | CNT_W | Bytes remaining |
| tot_done | output | 1 | Byte total has run out |
| wr_en | input | 1 | Halfword write request |
| wr_data | input | 16 | Halfword to write |
| wr_ack | output | 1 | Previous-cycle write accepted |
| dreq | output | 1 | DMA request |
| in_tok | input | 1 | IN token pulse from the serial engine |
| in_ack | input | 1 | Host ACK pulse for the packet in flight |
| tx_start | output | 1 | Packet transmission starts |
| tx_len | output | $clog2(MAXP+1) | Length in bytes of the packet started |
| tx_nak | output | 1 | Token answered with NAK |
| sie_raddr | input | $clog2(MAXP/2) | Buffer read address for the serial engine |
| sie_rdata | output | 16 | Buffer read data, one-cycle latency |

## Verification
The assertions check these rules on every clock:
- `dreq` is never high while a packet is queued.
- The cycle after a write in single mode has `dreq` low.
- A held request stays low while the total is spent.
- The odd-byte mark drops after the final write.
- The final-write mark drops on that packet's ACK.
- A spent count always reads zero.

Other behaviour needs a sequence of events and is shown only by the bench's scenarios:
- the packet lengths the serial engine sees;
- a zero-length packet appearing or not appearing after a full final packet;
- a NAK on an empty endpoint;
- buffer addressing and readback;
- the counter being frozen while disabled.

// File: rtl/usbf_in_pkg.sv
package usbf_in_pkg;
  localparam int unsigned CTL_W   = 6;
  localparam int unsigned CB_LAST = 0;
  localparam int unsigned CB_ODD  = 1;
  localparam int unsigned CB_NULL = 2;
  localparam int unsigned CB_SNGL = 3;
  localparam int unsigned CB_HOLD = 4;
  localparam int unsigned CB_TCNT = 5;
  localparam int unsigned HW_W    = 16;
  typedef logic [CTL_W-1:0] ctl_t;
endpackage

// File: rtl/ep_in_pktbuf.sv
module ep_in_pktbuf #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ep_in_bytecnt.sv
module ep_in_bytecnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec_en,
  input  logic [1:0]    dec_amt,
  output logic [CW-1:0] left,
  output logic          done,
  output logic          done_nxt
);
  logic [CW-1:0] amt;
  logic [CW-1:0] left_nxt;

  always_comb begin
    amt      = CW'(dec_amt);
    left_nxt = left;
    done_nxt = done;
    if (load) begin
      left_nxt = load_val;
      done_nxt = 1'b0;
    end else if (dec_en) begin
      left_nxt = (left > amt) ? left - amt : '0;
      if (left != '0 && left_nxt == '0) done_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
      done <= 1'b0;
    end else begin
      left <= left_nxt;
      done <= done_nxt;
    end
  end

  // R9
  spent_is_zero_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (left == '0));
endmodule

// File: rtl/usbf_in_xfer_end.sv
module usbf_in_xfer_end
  import usbf_in_pkg::*;
#(
  parameter int MAXP   = 64,
  parameter int CNT_W  = 16,
  localparam int FILL_W = $clog2(MAXP + 1),
  localparam int AW     = $clog2(MAXP / 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rd,
  input  logic              tot_we,
  input  logic [CNT_W-1:0]  tot_wdata,
  output logic [CNT_W-1:0]  tot_left,
  output logic              tot_done,
  input  logic              wr_en,
  input  logic [HW_W-1:0]   wr_data,
  output logic              wr_ack,
  output logic              dreq,
  input  logic              in_tok,
  input  logic              in_ack,
  output logic              tx_start,
  output logic [FILL_W-1:0] tx_len,
  output logic              tx_nak,
  input  logic [AW-1:0]     sie_raddr,
  output logic [HW_W-1:0]   sie_rdata
);
  localparam logic [FILL_W:0]   MAXP_X = (FILL_W + 1)'(MAXP);
  localparam logic [FILL_W-1:0] MAXP_L = FILL_W'(MAXP);

  ctl_t              ctl, ctl_n;
  logic [FILL_W-1:0] fill, fill_n;
  logic [FILL_W-1:0] pkt_len, pkt_len_n;
  logic              pkt_rdy, pkt_rdy_n;
  logic              pkt_last, pkt_last_n;
  logic              zlp_pend, zlp_n;
  logic              in_flight, fl_n;
  logic              fl_zlp, flz_n;
  logic              start_n, nak_n, dreq_n;
  logic [FILL_W-1:0] len_n;

  logic              accept, fin, ack_ok;
  logic [1:0]        nbytes;
  logic [FILL_W:0]   fill_sum;
  logic              done_nxt;

  assign accept   = wr_en && !pkt_rdy;
  assign fin      = accept && ctl[CB_LAST];
  assign nbytes   = (fin && ctl[CB_ODD]) ? 2'd1 : 2'd2;
  assign fill_sum = {1'b0, fill} + (FILL_W + 1)'(nbytes);
  assign ack_ok   = in_ack && in_flight;

  ep_in_pktbuf #(.AW(AW), .DW(HW_W)) u_buf (
    .clk   (clk),
    .we    (accept),
    .waddr (fill[AW:1]),
    .wdata (wr_data),
    .raddr (sie_raddr),
    .rdata (sie_rdata)
  );

  ep_in_bytecnt #(.CW(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (tot_we),
    .load_val (tot_wdata),
    .dec_en   (accept && ctl[CB_TCNT]),
    .dec_amt  (nbytes),
    .left     (tot_left),
    .done     (tot_done),
    .done_nxt (done_nxt)
  );

  // control word: hardware self-clears, software write overrides
  always_comb begin
    ctl_n = ctl;
    if (fin) ctl_n[CB_ODD] = 1'b0;
    if (ack_ok && !fl_zlp && pkt_last) ctl_n[CB_LAST] = 1'b0;
    if (ctl_we) ctl_n = ctl_wdata;
  end

  // buffer fill, packet queue, token handling
  always_comb begin
    fill_n     = fill;
    pkt_rdy_n  = pkt_rdy;
    pkt_len_n  = pkt_len;
    pkt_last_n = pkt_last;
    zlp_n      = zlp_pend;
    fl_n       = in_flight;
    flz_n      = fl_zlp;
    start_n    = 1'b0;
    nak_n      = 1'b0;
    len_n      = tx_len;

    if (accept) begin
      fill_n = fill_sum[FILL_W-1:0];
      if (fin || fill_sum == MAXP_X) begin
        pkt_rdy_n  = 1'b1;
        pkt_len_n  = fill_sum[FILL_W-1:0];
        pkt_last_n = fin;
      end
    end

    if (ack_ok) begin
      fl_n = 1'b0;
      if (fl_zlp) begin
        zlp_n = 1'b0;
      end else begin
        pkt_rdy_n = 1'b0;
        fill_n    = '0;
        if (pkt_last && pkt_len == MAXP_L && ctl[CB_NULL]) zlp_n = 1'b1;
      end
    end

    if (in_tok) begin
      if (zlp_pend) begin
        start_n = 1'b1;
        len_n   = '0;
        fl_n    = 1'b1;
        flz_n   = 1'b1;
      end else if (pkt_rdy) begin
        start_n = 1'b1;
        len_n   = pkt_len;
        fl_n    = 1'b1;
        flz_n   = 1'b0;
      end else begin
        nak_n = 1'b1;
      end
    end

    dreq_n = !pkt_rdy_n && !(ctl_n[CB_HOLD] && done_nxt) && !(ctl_n[CB_SNGL] && accept);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      fill      <= '0;
      pkt_len   <= '0;
      pkt_rdy   <= 1'b0;
      pkt_last  <= 1'b0;
      zlp_pend  <= 1'b0;
      in_flight <= 1'b0;
      fl_zlp    <= 1'b0;
      tx_start  <= 1'b0;
      tx_nak    <= 1'b0;
      tx_len    <= '0;
      dreq      <= 1'b0;
      wr_ack    <= 1'b0;
    end else begin
      ctl       <= ctl_n;
      fill      <= fill_n;
      pkt_len   <= pkt_len_n;
      pkt_rdy   <= pkt_rdy_n;
      pkt_last  <= pkt_last_n;
      zlp_pend  <= zlp_n;
      in_flight <= fl_n;
      fl_zlp    <= flz_n;
      tx_start  <= start_n;
      tx_nak    <= nak_n;
      tx_len    <= len_n;
      dreq      <= dreq_n;
      wr_ack    <= accept;
    end
  end

  assign ctl_rd = ctl;

  // R3
  queued_blocks_dreq_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_rdy |-> !dreq);

  // R3
  start_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> in_flight);

  // R7
  start_nak_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_start && tx_nak));

  // R8
  single_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && ctl[CB_SNGL] && !ctl_we) |=> !dreq);

  // R10
  hold_after_total_chk: assert property (@(posedge clk) disable iff (rst)
    (tot_done && ctl[CB_HOLD] && !tot_we && !ctl_we) |=> !dreq);

  // R5
  odd_autoclear_chk: assert property (@(posedge clk) disable iff (rst)
    (fin && ctl[CB_ODD] && !ctl_we) |=> !ctl_rd[CB_ODD]);

  // R4
  last_autoclear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_ok && !fl_zlp && pkt_last && !ctl_we) |=> !ctl_rd[CB_LAST]);
endmodule

// File: tb/usbf_in_xfer_end_tb.sv
module usbf_in_xfer_end_tb;
  localparam int MAXP   = 64;
  localparam int CNT_W  = 16;
  localparam int FILL_W = $clog2(MAXP + 1);
  localparam int AW     = $clog2(MAXP / 2);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ctl_we = 1'b0;
  logic [5:0]        ctl_wdata = '0;
  logic [5:0]        ctl_rd;
  logic              tot_we = 1'b0;
  logic [CNT_W-1:0]  tot_wdata = '0;
  logic [CNT_W-1:0]  tot_left;
  logic              tot_done;
  logic              wr_en = 1'b0;
  logic [15:0]       wr_data = '0;
  logic              wr_ack;
  logic              dreq;
  logic              in_tok = 1'b0;
  logic              in_ack = 1'b0;
  logic              tx_start;
  logic [FILL_W-1:0] tx_len;
  logic              tx_nak;
  logic [AW-1:0]     sie_raddr = '0;
  logic [15:0]       sie_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit started  = 1'b0;

  always #2 clk = ~clk;

  usbf_in_xfer_end #(.MAXP(MAXP), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rd(ctl_rd),
    .tot_we(tot_we), .tot_wdata(tot_wdata), .tot_left(tot_left), .tot_done(tot_done),
    .wr_en(wr_en), .wr_data(wr_data), .wr_ack(wr_ack), .dreq(dreq),
    .in_tok(in_tok), .in_ack(in_ack), .tx_start(tx_start), .tx_len(tx_len),
    .tx_nak(tx_nak), .sie_raddr(sie_raddr), .sie_rdata(sie_rdata)
  );

  // behavioural reference model
  int  m_ctl, m_fill, m_plen, m_left, m_txlen;
  bit  m_pr, m_pl, m_zp, m_fl, m_fz, m_done, m_start, m_nak, m_dreq, m_wack;

  always @(posedge clk) begin
    int  cn, nb, nl, plen0;
    bit  acc, fin, ackok, zp0, pr0;
    started <= 1'b1;
    if (rst) begin
      m_ctl = 0; m_fill = 0; m_plen = 0; m_left = 0; m_txlen = 0;
      m_pr = 0; m_pl = 0; m_zp = 0; m_fl = 0; m_fz = 0; m_done = 0;
      m_start = 0; m_nak = 0; m_dreq = 0; m_wack = 0;
    end else begin
      zp0 = m_zp; pr0 = m_pr; plen0 = m_plen;
      acc   = wr_en && !m_pr;
      fin   = acc && m_ctl[0];
      nb    = (fin && m_ctl[1]) ? 1 : 2;
      ackok = in_ack && m_fl;
      cn = m_ctl;
      if (fin) cn = cn & ~2;
      if (ackok && !m_fz && m_pl) cn = cn & ~1;
      if (ctl_we) cn = int'(ctl_wdata);
      if (tot_we) begin
        m_left = int'(tot_wdata); m_done = 0;
      end else if (acc && m_ctl[5]) begin
        nl = (m_left > nb) ? m_left - nb : 0;
        if (m_left != 0 && nl == 0) m_done = 1;
        m_left = nl;
      end
      if (acc) begin
        m_fill = m_fill + nb;
        if (fin || m_fill == MAXP) begin
          m_pr = 1; m_plen = m_fill; m_pl = fin;
        end
      end
      m_start = 0; m_nak = 0;
      if (ackok) begin
        m_fl = 0;
        if (m_fz) m_zp = 0;
        else begin
          m_pr = 0; m_fill = 0;
          if (m_pl && plen0 == MAXP && m_ctl[2]) m_zp = 1;
        end
      end
      if (in_tok) begin
        if (zp0) begin m_start = 1; m_txlen = 0; m_fl = 1; m_fz = 1; end
        else if (pr0) begin m_start = 1; m_txlen = plen0; m_fl = 1; m_fz = 0; end
        else m_nak = 1;
      end
      m_dreq = !m_pr && !(cn[4] && m_done) && !(cn[3] && acc);
      m_wack = acc;
      m_ctl  = cn;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (started) begin
      chk("R8",  "dreq vs model",     int'(dreq),     int'(m_dreq));
      chk("R3",  "wr_ack vs model",   int'(wr_ack),   int'(m_wack));
      chk("R3",  "tx_start vs model", int'(tx_start), int'(m_start));
      chk("R3",  "tx_len vs model",   int'(tx_len),   m_txlen);
      chk("R7",  "tx_nak vs model",   int'(tx_nak),   int'(m_nak));
      chk("R4",  "ctl_rd vs model",   int'(ctl_rd),   m_ctl);
      chk("R9",  "tot_left vs model", int'(tot_left), m_left);
      chk("R10", "tot_done vs model", int'(tot_done), int'(m_done));
    end
  end

  task automatic ctl_write(input logic [5:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic load_tot(input int v);
    @(negedge clk); tot_we = 1'b1; tot_wdata = CNT_W'(v);
    @(negedge clk); tot_we = 1'b0;
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tok();
    @(negedge clk); in_tok = 1'b1;
    @(negedge clk); in_tok = 1'b0;
  endtask

  task automatic hack();
    @(negedge clk); in_ack = 1'b1;
    @(negedge clk); in_ack = 1'b0;
  endtask

  task automatic rd(input int a);
    @(negedge clk); sie_raddr = AW'(a);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ctl_rd after reset", int'(ctl_rd), 0);
    chk("R1", "tot_left after reset", int'(tot_left), 0);
    chk("R1", "tot_done after reset", int'(tot_done), 0);
    chk("R1", "tx_start after reset", int'(tx_start), 0);

    // Scenario A: block mode, counter on, one full packet
    ctl_write(6'b100000);
    load_tot(64);
    wr(16'h1000);
    chk("R8", "block mode dreq at ack", int'(dreq), 1);
    for (int i = 1; i < 32; i++) wr(16'h1000 + 16'(i));
    chk("R9", "tot_left at end", int'(tot_left), 0);
    chk("R9", "tot_done at end", int'(tot_done), 1);
    chk("R3", "dreq with full buffer", int'(dreq), 0);
    wr(16'hDEAD);
    chk("R3", "write to full buffer acked", int'(wr_ack), 0);
    rd(5);
    chk("R2", "readback addr 5", int'(sie_rdata), 16'h1005);
    rd(31);
    chk("R2", "readback addr 31", int'(sie_rdata), 16'h101F);
    rd(0);
    chk("R3", "blocked write not stored", int'(sie_rdata), 16'h1000);
    tok();
    chk("R3", "tx_start full packet", int'(tx_start), 1);
    chk("R3", "tx_len full packet", int'(tx_len), MAXP);
    hack();
    chk("R10", "dreq back with hold off", int'(dreq), 1);

    // Scenario B: hold after total, odd final write
    ctl_write(6'b110000);
    load_tot(4);
    wr(16'h2000);
    wr(16'h2001);
    chk("R10", "tot_done with hold", int'(tot_done), 1);
    chk("R10", "dreq held off", int'(dreq), 0);
    load_tot(3);
    chk("R10", "dreq after reload", int'(dreq), 1);
    wr(16'h2222);
    ctl_write(6'b110011);
    wr(16'h0033);
    chk("R5", "odd mark cleared", int'(ctl_rd[1]), 0);
    chk("R4", "last mark kept before ack", int'(ctl_rd[0]), 1);
    chk("R9", "odd final decrement", int'(tot_left), 0);
    tok();
    chk("R5", "odd packet length", int'(tx_len), 7);
    hack();
    chk("R4", "last mark cleared on ack", int'(ctl_rd[0]), 0);
    tok();
    chk("R7", "nak on empty", int'(tx_nak), 1);
    chk("R7", "no start on empty", int'(tx_start), 0);

    // Scenario C: zero-length packet, counter disabled
    load_tot(10);
    ctl_write(6'b000100);
    for (int i = 0; i < 31; i++) wr(16'h3000 + 16'(i));
    chk("R9", "counter frozen when disabled", int'(tot_left), 10);
    ctl_write(6'b000101);
    wr(16'h30FF);
    tok();
    chk("R4", "final full packet length", int'(tx_len), MAXP);
    hack();
    tok();
    chk("R6", "zero-length start", int'(tx_start), 1);
    chk("R6", "zero-length len", int'(tx_len), 0);
    hack();
    tok();
    chk("R7", "nak after zero-length", int'(tx_nak), 1);

    // Scenario D: single mode, no zero-length packet
    ctl_write(6'b001000);
    wr(16'h4000);
    chk("R8", "single mode ack", int'(wr_ack), 1);
    chk("R8", "single mode dreq gap", int'(dreq), 0);
    @(negedge clk);
    chk("R8", "single mode dreq returns", int'(dreq), 1);
    for (int i = 1; i < 31; i++) wr(16'h4000 + 16'(i));
    ctl_write(6'b001001);
    wr(16'h40FF);
    tok();
    chk("R6", "full final packet len", int'(tx_len), MAXP);
    hack();
    tok();
    chk("R6", "no zero-length when disabled", int'(tx_nak), 1);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule